// File: doc/BRIEF.md
# Front-End Hazard and Branch Sequencer

This block drives the fetch and decode end of a five-stage in-order 32-bit integer pipeline. It owns the program counter, the fetch/decode pipeline register, and the decode/execute register that leads into the execute stage. Each cycle it presents the program counter on a fetch port and takes the instruction word back in the same cycle. It sends the two source register numbers of the decoded instruction to an external register file and takes the read data back. Execute, memory access, writeback and the operand bypass network sit outside. They see this block only through its decode/execute outputs.

When the instruction in execute is a load whose destination is a source of the instruction in decode, the block holds the counter and the decode register for one cycle. In that cycle it sends a control-free bubble into execute. Conditional equality branches are resolved in decode with the register-file operands. Fetch runs on the assumption that the branch is not taken. When the branch is taken, the counter is redirected and the one wrongly fetched instruction is replaced by the all-zero no-op word.

Top module: `fe_hazard_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, loads the all-zero no-op into decode (source indices read 0), and clears every execute control bit.
- R2: With no stall and no taken branch, the fetch address increases by 4 on each clock. The fetched word enters decode on the next cycle, and its decode reaches the execute outputs one cycle after that.
- R3: Opcode bits [31:26] are decoded as follows. 0x00 (register form) sets reg_write, reg_dst and alu_op=2. 0x23 (load) sets mem_read, reg_write, mem_to_reg and alu_src, with alu_op=0. 0x2B (store) sets mem_write and alu_src, with alu_op=0. 0x04 (branch-if-equal) sets alu_op=1 and nothing else. Every other opcode clears all controls. Source fields are bits [25:21] and [20:16], the destination field is [15:11], and the immediate is [15:0].
- R4: hazard_stall is high when ex_mem_read is set and ex_rt_idx is nonzero and equals the decode instruction's bits [25:21] or bits [20:16]. A load into register 0 never stalls.
- R5: During a stall cycle the fetch address and the decode register are not written, so both show the same values in the next cycle.
- R6: The cycle after a stall shows all execute control bits at zero, and a load-use stall lasts exactly one cycle.
- R7: A branch-if-equal in decode whose two register-file operands are equal raises branch_flush. The next fetch address is then the branch address + 4 + (sign-extended imm << 2).
- R8: After a taken branch, decode holds the all-zero no-op, which shows as source indices 0 and, one cycle later, as register-form controls with destination 0.
- R9: A branch-if-equal with unequal operands does not flush, and fetch continues at +4.
- R10: When a stall and a taken branch occur in the same cycle, the stall wins. The flush is suppressed and the branch is evaluated again in the following cycle.
- R11: A negative branch offset redirects fetch backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 32 | Program counter presented to the fetch port |
| fetch_word | input | 32 | Instruction word at fetch_addr |
| rf_rs_idx | output | 5 | First source register number of the decode instruction |
| rf_rt_idx | output | 5 | Second source register number of the decode instruction |
| rf_rs_data | input | 32 | Register file data for rf_rs_idx |
| rf_rt_data | input | 32 | Register file data for rf_rt_idx |
| hazard_stall | output | 1 | Load-use stall this cycle (counter and decode frozen, bubble sent) |
| branch_flush | output | 1 | Taken branch this cycle (redirect and squash) |
| ex_mem_read | output | 1 | Execute stage: memory read |
| ex_mem_write | output | 1 | Execute stage: memory write |
| ex_reg_write | output | 1 | Execute stage: register write |
| ex_mem_to_reg | output | 1 | Execute stage: writeback selects memory data |
| ex_alu_src | output | 1 | Execute stage: ALU second operand is immediate |
| ex_reg_dst | output | 1 | Execute stage: destination is bits [15:11] |
| ex_alu_op | output | 2 | Execute stage: ALU operation class |
| ex_rs_idx | output | 5 | Execute stage: first source number |
| ex_rt_idx | output | 5 | Execute stage: second source number |
| ex_rd_idx | output | 5 | Execute stage: register-form destination number |
| ex_funct | output | 6 | Execute stage: function field |
| ex_rs_val | output | 32 | Execute stage: first operand value |
| ex_rt_val | output | 32 | Execute stage: second operand value |
| ex_imm | output | 32 | Execute stage: sign-extended immediate |

## Verification
A wrong program counter shows at fetch_addr on the clock edge right after the fault. A decode register that was not held or not squashed shows at once on rf_rs_idx and rf_rt_idx, and it reaches the execute control outputs one cycle later. A missing or doubled bubble shows as nonzero execute controls in the cycle after hazard_stall. A stall that stays high too long shows as a fetch address that stops advancing. The stimulus therefore compares every port in every cycle, so any of these faults is caught within two cycles of where it first arises.

// File: rtl/fe_hazard_ctrl.sv
module fe_hazard_ctrl #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter logic [31:0] NOP_WORD = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] fetch_addr,
  input  logic [31:0] fetch_word,
  output logic [4:0]  rf_rs_idx,
  output logic [4:0]  rf_rt_idx,
  input  logic [31:0] rf_rs_data,
  input  logic [31:0] rf_rt_data,
  output logic        hazard_stall,
  output logic        branch_flush,
  output logic        ex_mem_read,
  output logic        ex_mem_write,
  output logic        ex_reg_write,
  output logic        ex_mem_to_reg,
  output logic        ex_alu_src,
  output logic        ex_reg_dst,
  output logic [1:0]  ex_alu_op,
  output logic [4:0]  ex_rs_idx,
  output logic [4:0]  ex_rt_idx,
  output logic [4:0]  ex_rd_idx,
  output logic [5:0]  ex_funct,
  output logic [31:0] ex_rs_val,
  output logic [31:0] ex_rt_val,
  output logic [31:0] ex_imm
);

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  logic [31:0] pc_q;
  logic [31:0] dec_word_q;
  logic [31:0] dec_pc4_q;

  wire [5:0]  dec_op   = dec_word_q[31:26];
  wire [4:0]  dec_rs   = dec_word_q[25:21];
  wire [4:0]  dec_rt   = dec_word_q[20:16];
  wire [4:0]  dec_rd   = dec_word_q[15:11];
  wire [5:0]  dec_fn   = dec_word_q[5:0];
  wire [31:0] dec_sext = {{16{dec_word_q[15]}}, dec_word_q[15:0]};

  wire [31:0] seq_pc    = pc_q + 32'd4;
  wire [31:0] jump_pc   = dec_pc4_q + {dec_sext[29:0], 2'b00};
  wire        load_dep  = ex_mem_read && (ex_rt_idx != 5'd0) &&
                          ((ex_rt_idx == dec_rs) || (ex_rt_idx == dec_rt));
  wire        ops_equal = (rf_rs_data == rf_rt_data);
  wire        advance   = !load_dep;

  assign hazard_stall = load_dep;
  assign branch_flush = (dec_op == OP_BEQ) && ops_equal && advance;
  assign fetch_addr   = pc_q;
  assign rf_rs_idx    = dec_rs;
  assign rf_rt_idx    = dec_rt;

  logic       c_mr, c_mw, c_rw, c_m2r, c_as, c_rd;
  logic [1:0] c_op;

  always_comb begin
    {c_mr, c_mw, c_rw, c_m2r, c_as, c_rd} = 6'b0;
    c_op = 2'd0;
    case (dec_op)
      OP_REG:   begin c_rw = 1'b1; c_rd = 1'b1; c_op = 2'd2; end
      OP_LOAD:  begin c_mr = 1'b1; c_rw = 1'b1; c_m2r = 1'b1; c_as = 1'b1; end
      OP_STORE: begin c_mw = 1'b1; c_as = 1'b1; end
      OP_BEQ:   c_op = 2'd1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= RESET_PC;
    else if (advance) pc_q <= branch_flush ? jump_pc : seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_word_q <= NOP_WORD;
      dec_pc4_q  <= 32'd0;
    end else if (advance) begin
      dec_word_q <= branch_flush ? NOP_WORD : fetch_word;
      dec_pc4_q  <= seq_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load_dep) begin
      ex_mem_read   <= 1'b0;
      ex_mem_write  <= 1'b0;
      ex_reg_write  <= 1'b0;
      ex_mem_to_reg <= 1'b0;
      ex_alu_src    <= 1'b0;
      ex_reg_dst    <= 1'b0;
      ex_alu_op     <= 2'd0;
    end else begin
      ex_mem_read   <= c_mr;
      ex_mem_write  <= c_mw;
      ex_reg_write  <= c_rw;
      ex_mem_to_reg <= c_m2r;
      ex_alu_src    <= c_as;
      ex_reg_dst    <= c_rd;
      ex_alu_op     <= c_op;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_rs_idx <= 5'd0;
      ex_rt_idx <= 5'd0;
      ex_rd_idx <= 5'd0;
      ex_funct  <= 6'd0;
      ex_rs_val <= 32'd0;
      ex_rt_val <= 32'd0;
      ex_imm    <= 32'd0;
    end else begin
      ex_rs_idx <= dec_rs;
      ex_rt_idx <= dec_rt;
      ex_rd_idx <= dec_rd;
      ex_funct  <= dec_fn;
      ex_rs_val <= rf_rs_data;
      ex_rt_val <= rf_rt_data;
      ex_imm    <= dec_sext;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr == RESET_PC) && !ex_reg_write && !ex_mem_read && !ex_mem_write);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!hazard_stall && !branch_flush) |=> fetch_addr == $past(fetch_addr) + 32'd4);

  assert_zero_dest_R4: assert property (@(posedge clk) disable iff (rst)
    (ex_mem_read && ex_rt_idx == 5'd0) |-> !hazard_stall);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    hazard_stall |=> $stable(fetch_addr) && $stable(rf_rs_idx) && $stable(rf_rt_idx));

  assert_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    hazard_stall |=> !ex_mem_read && !ex_mem_write && !ex_reg_write && ex_alu_op == 2'd0);

  assert_single_stall_R6: assert property (@(posedge clk) disable iff (rst)
    hazard_stall |=> !hazard_stall);

  assert_squash_nop_R8: assert property (@(posedge clk) disable iff (rst)
    branch_flush |=> rf_rs_idx == 5'd0 && rf_rt_idx == 5'd0);

  assert_stall_first_R10: assert property (@(posedge clk) disable iff (rst)
    !(hazard_stall && branch_flush));

endmodule

// File: tb/fe_hazard_ctrl_bench.sv
module fe_hazard_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] fetch_addr, fetch_word, rf_rs_data, rf_rt_data;
  logic [4:0]  rf_rs_idx, rf_rt_idx, ex_rs_idx, ex_rt_idx, ex_rd_idx;
  logic        hazard_stall, branch_flush;
  logic        ex_mem_read, ex_mem_write, ex_reg_write, ex_mem_to_reg, ex_alu_src, ex_reg_dst;
  logic [1:0]  ex_alu_op;
  logic [5:0]  ex_funct;
  logic [31:0] ex_rs_val, ex_rt_val, ex_imm;

  fe_hazard_ctrl u_fe_hazard_ctrl (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .rf_rs_idx(rf_rs_idx), .rf_rt_idx(rf_rt_idx), .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
    .hazard_stall(hazard_stall), .branch_flush(branch_flush),
    .ex_mem_read(ex_mem_read), .ex_mem_write(ex_mem_write), .ex_reg_write(ex_reg_write),
    .ex_mem_to_reg(ex_mem_to_reg), .ex_alu_src(ex_alu_src), .ex_reg_dst(ex_reg_dst),
    .ex_alu_op(ex_alu_op), .ex_rs_idx(ex_rs_idx), .ex_rt_idx(ex_rt_idx), .ex_rd_idx(ex_rd_idx),
    .ex_funct(ex_funct), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val), .ex_imm(ex_imm)
  );

  wire [7:0] ctl = {ex_mem_read, ex_mem_write, ex_reg_write, ex_mem_to_reg,
                    ex_alu_src, ex_reg_dst, ex_alu_op};

  localparam int N = 18;
  localparam logic [31:0] V_WORD [N] = '{
    32'h8C62_0014, 32'h0045_6020, 32'h0182_6825, 32'h0182_6825, 32'hACC4_0000, 32'h8C20_0000,
    32'h0000_0820, 32'h10E8_0003, 32'h2401_0001, 32'h112A_FFFF, 32'h8C2B_0000, 32'h118B_FFFC,
    32'h2402_0002, 32'h2402_0002, 32'hFC00_0000, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_RSD [N] = '{0,0,0,0,0,0,0,0,5,0,1,0,7,7,0,0,0,0};
  localparam logic [31:0] V_RTD [N] = '{0,0,0,0,0,0,0,0,5,0,2,0,7,7,0,0,0,0};
  localparam logic [31:0] V_PC  [N] = '{0,4,8,8,12,16,20,24,28,40,44,48,52,52,36,40,44,48};
  localparam logic        V_STL [N] = '{0,0,1,0,0,0,0,0,0,0,0,0,1,0,0,0,0,0};
  localparam logic        V_FLS [N] = '{0,0,0,0,0,0,0,0,1,0,0,0,0,1,0,0,0,0};
  localparam logic [7:0]  V_CTL [N] = '{8'h00,8'h26,8'hB8,8'h00,8'h26,8'h26,8'h48,8'hB8,8'h26,
                                        8'h01,8'h26,8'h01,8'hB8,8'h00,8'h01,8'h26,8'h00,8'h26};
  localparam logic [4:0]  V_RSI [N] = '{0,3,2,2,12,6,1,0,7,0,9,1,12,12,0,0,0,0};

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input int step, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s step=%0d actual=%h expected=%h", tag, step, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fetch_word = 32'h0; rf_rs_data = 32'h0; rf_rt_data = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      fetch_word = V_WORD[i]; rf_rs_data = V_RSD[i]; rf_rt_data = V_RTD[i];
      #1;
      chk("R1 R2 R5 R7 R9 R11 fetch_addr", i, fetch_addr, V_PC[i]);
      chk("R4 R6 R10 hazard_stall", i, 32'(hazard_stall), 32'(V_STL[i]));
      chk("R7 R9 R10 branch_flush", i, 32'(branch_flush), 32'(V_FLS[i]));
      chk("R1 R3 R6 R8 ex controls", i, 32'(ctl), 32'(V_CTL[i]));
      chk("R1 R5 R8 rf_rs_idx", i, 32'(rf_rs_idx), 32'(V_RSI[i]));
      @(negedge clk);
    end

    // R8: nop after a squash reaches execute with destination 0
    chk("R8 squashed nop rd", 99, 32'(ex_rd_idx), 32'd0);

    // R1: reset in the middle of a run
    fetch_word = 32'h8C62_0014;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 fetch_addr after reset", 100, fetch_addr, 32'd0);
    chk("R1 controls after reset", 100, 32'(ctl), 32'd0);
    chk("R1 decode nop after reset", 100, 32'({rf_rs_idx, rf_rt_idx}), 32'd0);
    chk("R1 no stall after reset", 100, 32'(hazard_stall), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule